// File: doc/BRIEF.md
# Eight-Point Fixed-Point Inverse DCT Datapath

This block computes a one-dimensional eight-point inverse discrete cosine transform on a row or column of signed 16-bit coefficients. The result is bit-exact with the integer transform used by the VP9 video format. It is one lane of a larger 2-D inverse-transform engine. Sequencing, transposition, prediction add and pixel clamping all sit outside it.

Every multiply uses a Q14 trigonometric constant. Each product is followed by an arithmetic right shift of 14 that rounds half up. Three structures make up the datapath: a first layer of four rotations, a layer of add/subtract butterflies, and one more pi/4 rotation on the odd half. A final mirrored butterfly produces the eight outputs. All internal words are signed 32-bit.

The parameter `NUM_STAGES` sets the register depth, from 0 to 3:

- 0 is purely combinational.
- 1 registers the outputs.
- 2 also registers after the butterfly layer.
- 3 also registers after the first rotations.

Top module: `inv_dct8_1d`

## Requirements
- R1: After reset is released with `NUM_STAGES` >= 1, `valid_o` is 0 and all of `y_o` is 0 until the first input strobe reaches the output.
- R2: `valid_o` is `valid_i` delayed by exactly `NUM_STAGES` clock cycles. An input may be accepted in every cycle, and one result leaves in every cycle.
- R3: Lane i of `coef_i` is bits [16*i+15:16*i], a signed 16-bit value. Lane i of `y_o` is bits [32*i+31:32*i], a signed 32-bit value.
- R4: With R(p) = (p + 8192) >>> 14, the even half is computed as follows:
  - t0 = R((x0+x4)*11585) and t1 = R((x0-x4)*11585).
  - t2 = R(x2*6270 - x6*15137) and t3 = R(x2*15137 + x6*6270).
  - e0 = t0+t3, e1 = t1+t2, e2 = t1-t2 and e3 = t0-t3.
- R5: The odd half is computed as follows:
  - t4 = R(x1*3196 - x7*16069) and t7 = R(x1*16069 + x7*3196).
  - t5 = R(x5*13623 - x3*9102) and t6 = R(x5*9102 + x3*13623).
  - o4 = t4+t5, o5 = t4-t5, o6 = t7-t6 and o7 = t7+t6.
  - p5 = R((o6-o5)*11585) and p6 = R((o6+o5)*11585).
- R6: The outputs are formed as follows:
  - y0 = e0+o7 and y7 = e0-o7.
  - y1 = e1+p6 and y6 = e1-p6.
  - y2 = e2+p5 and y5 = e2-p5.
  - y3 = e3+o4 and y4 = e3-o4.
- R7: Results match the integer model exactly for every input in the signed 16-bit range, including all combinations of +32767 and -32768. No intermediate value wraps.
- R8: An all-zero input gives an all-zero output.
- R9: An input with only lane 0 nonzero gives eight equal outputs, each R(x0*11585).
- R10: The mirrored outputs (y0,y7), (y1,y6), (y2,y5) and (y3,y4) always have equal least significant bits.
- R11: With `NUM_STAGES` >= 1, `y_o` holds its value in every cycle where `valid_o` is 0. Data registers load only behind a valid strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input coefficients valid strobe |
| coef_i | input | 128 | Eight signed 16-bit coefficients, lane 0 at the LSBs |
| valid_o | output | 1 | Output valid strobe |
| y_o | output | 256 | Eight signed 32-bit results, lane 0 at the LSBs |

## Verification
The checker's properties assume that `coef_i` is stable and meaningful whenever `valid_i` is high. The DC-flat and zero-output properties key on a delayed copy of the input pattern. That copy is taken only on strobed cycles, so it is only meaningful when the input is meaningful.

The stimulus changes inputs only on the falling edge and never drives X. It holds `coef_i` at a defined value while the strobe is low. Random and extreme vectors are drawn only from the signed 16-bit range. Under that assumption the 32-bit intermediates cannot wrap, and the parity and flatness properties are exact.

// File: rtl/inv_dct8_pkg.sv
package inv_dct8_pkg;
  localparam int LANES    = 8;
  localparam int IN_W     = 16;
  localparam int WORD_W   = 32;
  localparam int FRAC_W   = 14;
  localparam int ROT_N    = 4;
  localparam int MAX_STGS = 3;

  typedef logic signed [WORD_W-1:0] word_t;

  // Q14 trig constants
  localparam int K_PI4 = 11585;
  localparam int K_C24 = 6270;
  localparam int K_C8  = 15137;
  localparam int K_C28 = 3196;
  localparam int K_C4  = 16069;
  localparam int K_C20 = 9102;
  localparam int K_C12 = 13623;

  // first-layer rotations: (a, b, c1, c2) -> lo = a*c1-b*c2, hi = a*c2+b*c1
  localparam int ROT_A [ROT_N]  = '{0, 2, 1, 5};
  localparam int ROT_B [ROT_N]  = '{4, 6, 7, 3};
  localparam int ROT_C1[ROT_N]  = '{K_PI4, K_C24, K_C28, K_C12};
  localparam int ROT_C2[ROT_N]  = '{K_PI4, K_C8,  K_C4,  K_C20};

  function automatic word_t q14_round(input word_t p);
    return (p + (word_t'(1) <<< (FRAC_W-1))) >>> FRAC_W;
  endfunction
endpackage

// File: rtl/inv_dct8_rot.sv
module inv_dct8_rot
  import inv_dct8_pkg::*;
#(
  parameter int C1 = K_PI4,
  parameter int C2 = K_PI4
) (
  input  word_t a_i,
  input  word_t b_i,
  output word_t lo_o,
  output word_t hi_o
);
  localparam word_t K1 = word_t'(C1);
  localparam word_t K2 = word_t'(C2);

  word_t prod_lo, prod_hi;

  always_comb begin
    prod_lo = a_i * K1 - b_i * K2;
    prod_hi = a_i * K2 + b_i * K1;
  end

  assign lo_o = q14_round(prod_lo);
  assign hi_o = q14_round(prod_hi);
endmodule

// File: rtl/inv_dct8_pipe.sv
module inv_dct8_pipe
  import inv_dct8_pkg::*;
#(
  parameter bit ENABLE = 1'b1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  vld_i,
  input  word_t d_i [LANES],
  output logic  vld_o,
  output word_t d_o [LANES]
);
  if (ENABLE) begin : g_reg
    logic  vld_q;
    word_t d_q [LANES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        for (int i = 0; i < LANES; i++) d_q[i] <= '0;
      end else begin
        vld_q <= vld_i;
        if (vld_i) begin
          for (int i = 0; i < LANES; i++) d_q[i] <= d_i[i];
        end
      end
    end

    assign vld_o = vld_q;
    assign d_o   = d_q;
  end else begin : g_wire
    assign vld_o = vld_i;
    assign d_o   = d_i;
  end
endmodule

// File: rtl/inv_dct8_1d.sv
module inv_dct8_1d
  import inv_dct8_pkg::*;
#(
  parameter int NUM_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [LANES*IN_W-1:0]    coef_i,
  output logic                     valid_o,
  output logic [LANES*WORD_W-1:0]  y_o
);
  localparam bit REG_ROT  = (NUM_STAGES >= 3);
  localparam bit REG_BFLY = (NUM_STAGES >= 2);
  localparam bit REG_OUT  = (NUM_STAGES >= 1);

  initial begin
    if (NUM_STAGES < 0 || NUM_STAGES > MAX_STGS)
      $error("NUM_STAGES out of range");
  end

  // widen inputs
  word_t x [LANES];
  for (genvar i = 0; i < LANES; i++) begin : g_widen
    assign x[i] = word_t'($signed(coef_i[i*IN_W +: IN_W]));
  end

  // layer 1: four rotations
  word_t rot_lo [ROT_N];
  word_t rot_hi [ROT_N];
  for (genvar k = 0; k < ROT_N; k++) begin : g_rot
    inv_dct8_rot #(.C1(ROT_C1[k]), .C2(ROT_C2[k])) u_rot (
      .a_i (x[ROT_A[k]]),
      .b_i (x[ROT_B[k]]),
      .lo_o(rot_lo[k]),
      .hi_o(rot_hi[k])
    );
  end

  // order: t0..t7
  word_t t_d [LANES];
  assign t_d[0] = rot_hi[0];
  assign t_d[1] = rot_lo[0];
  assign t_d[2] = rot_lo[1];
  assign t_d[3] = rot_hi[1];
  assign t_d[4] = rot_lo[2];
  assign t_d[5] = rot_lo[3];
  assign t_d[6] = rot_hi[3];
  assign t_d[7] = rot_hi[2];

  logic  t_vld;
  word_t t [LANES];
  inv_dct8_pipe #(.ENABLE(REG_ROT)) u_pipe_rot (
    .clk_i, .rst_ni,
    .vld_i(valid_i), .d_i(t_d),
    .vld_o(t_vld),   .d_o(t)
  );

  // layer 2: butterflies; slots 0..3 = e0..e3, 4..7 = o4..o7
  word_t b_d [LANES];
  always_comb begin
    b_d[0] = t[0] + t[3];
    b_d[1] = t[1] + t[2];
    b_d[2] = t[1] - t[2];
    b_d[3] = t[0] - t[3];
    b_d[4] = t[4] + t[5];
    b_d[5] = t[4] - t[5];
    b_d[6] = t[7] - t[6];
    b_d[7] = t[7] + t[6];
  end

  logic  b_vld;
  word_t b [LANES];
  inv_dct8_pipe #(.ENABLE(REG_BFLY)) u_pipe_bfly (
    .clk_i, .rst_ni,
    .vld_i(t_vld), .d_i(b_d),
    .vld_o(b_vld), .d_o(b)
  );

  // layer 3: pi/4 rotation on o5/o6
  word_t p5, p6;
  inv_dct8_rot #(.C1(K_PI4), .C2(K_PI4)) u_rot_odd (
    .a_i (b[6]),
    .b_i (b[5]),
    .lo_o(p5),
    .hi_o(p6)
  );

  word_t y_d [LANES];
  always_comb begin
    y_d[0] = b[0] + b[7];
    y_d[1] = b[1] + p6;
    y_d[2] = b[2] + p5;
    y_d[3] = b[3] + b[4];
    y_d[4] = b[3] - b[4];
    y_d[5] = b[2] - p5;
    y_d[6] = b[1] - p6;
    y_d[7] = b[0] - b[7];
  end

  word_t y [LANES];
  inv_dct8_pipe #(.ENABLE(REG_OUT)) u_pipe_out (
    .clk_i, .rst_ni,
    .vld_i(b_vld),   .d_i(y_d),
    .vld_o(valid_o), .d_o(y)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_pack
    assign y_o[i*WORD_W +: WORD_W] = y[i];
  end
endmodule

// File: rtl/inv_dct8_1d_chk.sv
module inv_dct8_1d_chk
  import inv_dct8_pkg::*;
#(
  parameter int NUM_STAGES = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic [LANES*IN_W-1:0]   coef_i,
  input logic                    valid_o,
  input logic [LANES*WORD_W-1:0] y_o
);
  logic zero_now, dc_now;
  assign zero_now = (coef_i == '0);
  assign dc_now   = (coef_i[LANES*IN_W-1:IN_W] == '0);

  logic [MAX_STGS:0] vld_sr, zero_sr, dc_sr;
  assign vld_sr[0]  = valid_i;
  assign zero_sr[0] = zero_now;
  assign dc_sr[0]   = dc_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_sr[MAX_STGS:1]  <= '0;
      zero_sr[MAX_STGS:1] <= '0;
      dc_sr[MAX_STGS:1]   <= '0;
    end else begin
      vld_sr[MAX_STGS:1]  <= vld_sr[MAX_STGS-1:0];
      zero_sr[MAX_STGS:1] <= zero_sr[MAX_STGS-1:0];
      dc_sr[MAX_STGS:1]   <= dc_sr[MAX_STGS-1:0];
    end
  end

  logic vld_d, zero_d, dc_d;
  assign vld_d  = vld_sr[NUM_STAGES];
  assign zero_d = zero_sr[NUM_STAGES];
  assign dc_d   = dc_sr[NUM_STAGES];

  logic [LANES-1:0] flat;
  for (genvar i = 0; i < LANES; i++) begin : g_flat
    assign flat[i] = (y_o[i*WORD_W +: WORD_W] == y_o[WORD_W-1:0]);
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == vld_d); // R2

  AST_ZERO_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && zero_d) |-> (y_o == '0)); // R8

  AST_DC_FLAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && dc_d) |-> (&flat)); // R9

  AST_MIRROR_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ({y_o[0], y_o[32], y_o[64], y_o[96]} ==
                 {y_o[224], y_o[192], y_o[160], y_o[128]})); // R10

  if (NUM_STAGES >= 1) begin : g_hold
    AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_o |-> $stable(y_o)); // R11
  end
endmodule

bind inv_dct8_1d inv_dct8_1d_chk #(.NUM_STAGES(NUM_STAGES)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .coef_i (coef_i),
  .valid_o(valid_o),
  .y_o    (y_o)
);

// File: tb/inv_dct8_1d_bench.sv
module inv_dct8_1d_bench;
  localparam int L     = 2;
  localparam int MAXV  = 512;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [127:0] coef_i = '0;
  logic         valid_o;
  logic [255:0] y_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [127:0] vin  [MAXV];
  logic [255:0] vexp [MAXV];

  always #5 clk = ~clk;

  inv_dct8_1d #(.NUM_STAGES(L)) u_inv_dct8_1d (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .coef_i(coef_i),
    .valid_o(valid_o), .y_o(y_o)
  );

  function automatic longint rq(input longint p);
    return (p + 8192) >>> 14;
  endfunction

  function automatic logic [255:0] model(input logic [127:0] v);
    longint x [8];
    longint t0, t1, t2, t3, t4, t5, t6, t7;
    longint e0, e1, e2, e3, o4, o5, o6, o7, p5, p6;
    longint y [8];
    logic [255:0] r;
    for (int i = 0; i < 8; i++) x[i] = longint'($signed(v[16*i +: 16]));
    t0 = rq((x[0] + x[4]) * 11585);
    t1 = rq((x[0] - x[4]) * 11585);
    t2 = rq(x[2] * 6270 - x[6] * 15137);
    t3 = rq(x[2] * 15137 + x[6] * 6270);
    t4 = rq(x[1] * 3196 - x[7] * 16069);
    t7 = rq(x[1] * 16069 + x[7] * 3196);
    t5 = rq(x[5] * 13623 - x[3] * 9102);
    t6 = rq(x[5] * 9102 + x[3] * 13623);
    e0 = t0 + t3; e1 = t1 + t2; e2 = t1 - t2; e3 = t0 - t3;
    o4 = t4 + t5; o5 = t4 - t5; o6 = t7 - t6; o7 = t7 + t6;
    p5 = rq((o6 - o5) * 11585);
    p6 = rq((o6 + o5) * 11585);
    y[0] = e0 + o7; y[1] = e1 + p6; y[2] = e2 + p5; y[3] = e3 + o4;
    y[4] = e3 - o4; y[5] = e2 - p5; y[6] = e1 - p6; y[7] = e0 - o7;
    for (int i = 0; i < 8; i++) r[32*i +: 32] = y[i][31:0];
    return r;
  endfunction

  task automatic check(input string req, input bit ok, input logic [255:0] act,
                       input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // stream vin[0..n-1] back-to-back; check each result L cycles later
  task automatic run_batch(input string req, input int n);
    for (int i = 0; i < n; i++) vexp[i] = model(vin[i]);
    for (int c = 0; c < n + L; c++) begin
      @(negedge clk);
      if (c < n) begin
        valid_i = 1'b1;
        coef_i  = vin[c];
      end else begin
        valid_i = 1'b0;
      end
      #1;
      if (c >= L) begin
        check(req, valid_o === 1'b1 && y_o === vexp[c-L], y_o, vexp[c-L]);
      end
    end
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    check("R1", valid_o === 1'b0 && y_o === '0, y_o, '0);
  endtask

  task automatic t_latency();
    logic [255:0] e;
    vin[0] = {16'sd7, 16'sd6, 16'sd5, 16'sd4, 16'sd3, 16'sd2, 16'sd1, 16'sd100};
    e = model(vin[0]);
    @(negedge clk);
    valid_i = 1'b1; coef_i = vin[0];
    @(negedge clk);
    valid_i = 1'b0; coef_i = '0;
    for (int k = 1; k < L; k++) begin
      check("R2 early", valid_o === 1'b0, {255'd0, valid_o}, '0);
      @(negedge clk);
    end
    check("R2 on time", valid_o === 1'b1 && y_o === e, y_o, e);
    @(negedge clk);
    check("R2 one pulse", valid_o === 1'b0, {255'd0, valid_o}, '0);
  endtask

  task automatic t_lanes();
    int n = 0;
    // single-lane impulses at several amplitudes exercise lane order and each rotation
    for (int ln = 0; ln < 8; ln++) begin
      vin[n] = '0; vin[n][16*ln +: 16] = 16'sd1000;   n++;
      vin[n] = '0; vin[n][16*ln +: 16] = -16'sd77;    n++;
      vin[n] = '0; vin[n][16*ln +: 16] = 16'sd1;      n++;
    end
    run_batch("R3 lane order", n);
  endtask

  task automatic t_even_odd();
    int n = 0;
    for (int k = 0; k < 32; k++) begin
      vin[n] = '0;  // even lanes only
      for (int ln = 0; ln < 8; ln += 2) vin[n][16*ln +: 16] = 16'($urandom_range(0, 65535));
      n++;
    end
    run_batch("R4 even half", n);
    n = 0;
    for (int k = 0; k < 32; k++) begin
      vin[n] = '0;  // odd lanes only
      for (int ln = 1; ln < 8; ln += 2) vin[n][16*ln +: 16] = 16'($urandom_range(0, 65535));
      n++;
    end
    run_batch("R5 odd half", n);
  endtask

  task automatic t_random();
    for (int blk = 0; blk < 4; blk++) begin
      for (int i = 0; i < MAXV; i++)
        vin[i] = {$urandom, $urandom, $urandom, $urandom};
      run_batch("R6 random", MAXV);
    end
    for (int i = 0; i < 128; i++) begin
      for (int ln = 0; ln < 8; ln++) vin[i][16*ln +: 16] = 16'($signed($urandom_range(0, 512)) - 256);
    end
    run_batch("R6 small", 128);
  endtask

  task automatic t_extreme();
    for (int p = 0; p < 256; p++) begin
      for (int ln = 0; ln < 8; ln++)
        vin[p][16*ln +: 16] = p[ln] ? 16'h8000 : 16'h7fff;
    end
    run_batch("R7 extremes", 256);
    for (int p = 0; p < 256; p++) begin
      for (int ln = 0; ln < 8; ln++)
        vin[p][16*ln +: 16] = p[ln] ? 16'h8000 : 16'h0000;
    end
    run_batch("R7 min/zero", 256);
  endtask

  task automatic t_zero();
    vin[0] = '0;
    vin[1] = '0;
    run_batch("R8 zero", 2);
  endtask

  task automatic t_dc();
    logic [255:0] e;
    logic [31:0]  d;
    int vals [6] = '{1, -1, 32767, -32768, 4095, -12345};
    for (int i = 0; i < 6; i++) begin
      vin[0] = '0;
      vin[0][15:0] = 16'(vals[i]);
      d = 32'(rq(longint'(vals[i]) * 11585));
      e = {8{d}};
      run_batch("R9 dc", 1);
      check("R9 flat", vexp[0] === e, vexp[0], e);
    end
  endtask

  task automatic t_parity();
    logic [3:0] a, b;
    for (int i = 0; i < 64; i++) vin[i] = {$urandom, $urandom, $urandom, $urandom};
    for (int c = 0; c < 64 + L; c++) begin
      @(negedge clk);
      valid_i = (c < 64);
      if (c < 64) coef_i = vin[c];
      #1;
      if (c >= L) begin
        a = {y_o[0], y_o[32], y_o[64], y_o[96]};
        b = {y_o[224], y_o[192], y_o[160], y_o[128]};
        check("R10 parity", a === b, {252'd0, a}, {252'd0, b});
      end
    end
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic t_hold();
    logic [255:0] last;
    vin[0] = {16'sd900, -16'sd3, 16'sd44, 16'sd0, -16'sd2000, 16'sd12, 16'sd5, -16'sd31000};
    run_batch("R11 load", 1);
    last = vexp[0];
    coef_i = {8{16'h1234}};  // no strobe
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R11 hold", valid_o === 1'b0 && y_o === last, y_o, last);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_lanes();
    t_even_odd();
    t_random();
    t_extreme();
    t_zero();
    t_dc();
    t_parity();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule